// File: doc/BRIEF.md
# Packed Halfword Saturating SIMD ALU

This block takes two 64-bit operands and treats each as four independent 16-bit lanes. For every lane it computes one of seven packed operations, selected by a 3-bit operation code. The operations are signed saturating add and subtract, and add and subtract with a mixed unsigned/signed view that clamps to the unsigned range. It also provides an average that rounds by folding the dropped bit back in, and two shift-then-add operations with signed saturation that use a 2-bit shift amount.

The four lane results are packed back into one 64-bit word and captured in a register on the rising clock edge when the request is valid. A registered valid flag follows one cycle after the request. Flags, traps and multiplication are not provided. The block sits inside an execution pipeline as a single-cycle multimedia unit.

Top module: `hsimd_alu`

## Requirements
- R1: Lane k (k = 0..3) of the result occupies bits [16k+15:16k] and depends only on bits [16k+15:16k] of both operands and on the shared opcode and shift amount.
- R2: Opcode 0 (signed add) and opcode 2 (signed subtract, first minus second) treat both lanes as two's complement and clamp the exact result to the range -32768..32767.
- R3: Opcode 1 (mixed add) and opcode 3 (mixed subtract, first minus second) read the first operand lane as unsigned and the second as two's complement, and clamp the exact result to the range 0..65535.
- R4: Opcode 4 (average) forms the 17-bit unsigned sum of both lanes; the lane result is that sum shifted right by one with its least significant bit OR-ed into bit 0.
- R5: Opcode 5 (shift-left-add) shifts the signed first lane left by the shift amount (0..3), adds the signed second lane and clamps the exact result to -32768..32767.
- R6: Opcode 6 (shift-right-add) shifts the signed first lane right arithmetically by the shift amount (0..3), adds the signed second lane and clamps the result to -32768..32767.
- R7: Opcode 7 is undefined and yields an all-zero result.
- R8: A request presented with `in_valid` high at a rising edge appears on `result` with `out_valid` high after that edge; `out_valid` is low after any edge at which `in_valid` was low.
- R9: While `in_valid` is low, `result` keeps its last value regardless of the opcode, operands and shift amount.
- R10: With `rst` high at a rising edge, `out_valid` and `result` are zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0..6 defined, 7 undefined) |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| shamt | input | 2 | Shift amount for opcodes 5 and 6 |
| out_valid | output | 1 | Registered valid, one cycle after request |
| result | output | 64 | Registered packed result |

## Verification
Every vector places a different corner in each lane, such as positive overflow, negative overflow, an in-range value and a negative in-range value. This way a lane that reads the wrong slice or clamps to the wrong bound shows up at its own position. The mixed add and subtract vectors use first-lane values above 32767 and negative second lanes, which separates unsigned from signed interpretation of the first operand. The average vectors mix even and odd sums to tell the OR rounding apart from truncation or round-half-up. The shift vectors use amounts 0 to 3, with values that only overflow after the shift and a negative odd value shifted right, which checks the arithmetic floor.

// File: rtl/hsimd_pkg.sv
package hsimd_pkg;

    localparam int LANE_W_DEF = 16;
    localparam int LANES_DEF  = 4;
    localparam int SH_W_DEF   = 2;
    localparam int OP_W       = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_SS = 3'd0,
        OP_ADD_US = 3'd1,
        OP_SUB_SS = 3'd2,
        OP_SUB_US = 3'd3,
        OP_AVG    = 3'd4,
        OP_SHLADD = 3'd5,
        OP_SHRADD = 3'd6,
        OP_NONE   = 3'd7
    } hsimd_op_e;

endpackage

// File: rtl/hsimd_clamp.sv
module hsimd_clamp #(
    parameter int LANE_W = 16,
    parameter int WIDE_W = 20
) (
    input  logic signed [WIDE_W-1:0] val,
    input  logic                     uns_mode,
    output logic        [LANE_W-1:0] clamped
);

    localparam logic signed [WIDE_W-1:0] SMAX = WIDE_W'((1 << (LANE_W-1)) - 1);
    localparam logic signed [WIDE_W-1:0] SMIN = -WIDE_W'(1 << (LANE_W-1));
    localparam logic signed [WIDE_W-1:0] UMAX = WIDE_W'((1 << LANE_W) - 1);
    localparam logic signed [WIDE_W-1:0] UMIN = '0;

    logic signed [WIDE_W-1:0] hi_lim;
    logic signed [WIDE_W-1:0] lo_lim;

    always_comb begin
        hi_lim = uns_mode ? UMAX : SMAX;
        lo_lim = uns_mode ? UMIN : SMIN;
        if (val > hi_lim) begin
            clamped = hi_lim[LANE_W-1:0];
        end else if (val < lo_lim) begin
            clamped = lo_lim[LANE_W-1:0];
        end else begin
            clamped = val[LANE_W-1:0];
        end
    end

endmodule

// File: rtl/hsimd_lane.sv
module hsimd_lane
    import hsimd_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int SH_W   = 2
) (
    input  logic [OP_W-1:0]   op,
    input  logic [SH_W-1:0]   shamt,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] y
);

    localparam int SH_MAX = (1 << SH_W) - 1;
    localparam int WIDE_W = LANE_W + SH_MAX + 1;
    localparam int EXT_W  = WIDE_W - LANE_W;

    logic signed [WIDE_W-1:0] a_s;
    logic signed [WIDE_W-1:0] a_u;
    logic signed [WIDE_W-1:0] b_s;
    logic signed [WIDE_W-1:0] wide_d;
    logic                     uns_d;
    logic        [LANE_W:0]   sum_avg;
    logic        [LANE_W-1:0] avg_d;
    logic        [LANE_W-1:0] sat_y;

    always_comb begin
        a_s     = {{EXT_W{a[LANE_W-1]}}, a};
        a_u     = {{EXT_W{1'b0}}, a};
        b_s     = {{EXT_W{b[LANE_W-1]}}, b};
        sum_avg = {1'b0, a} + {1'b0, b};
        avg_d   = sum_avg[LANE_W:1] | {{(LANE_W-1){1'b0}}, sum_avg[0]};
        uns_d   = 1'b0;
        wide_d  = '0;
        case (hsimd_op_e'(op))
            OP_ADD_SS: wide_d = a_s + b_s;
            OP_ADD_US: begin
                wide_d = a_u + b_s;
                uns_d  = 1'b1;
            end
            OP_SUB_SS: wide_d = a_s - b_s;
            OP_SUB_US: begin
                wide_d = a_u - b_s;
                uns_d  = 1'b1;
            end
            OP_SHLADD: wide_d = (a_s <<< shamt) + b_s;
            OP_SHRADD: wide_d = (a_s >>> shamt) + b_s;
            default:   wide_d = '0;
        endcase
    end

    hsimd_clamp #(
        .LANE_W(LANE_W),
        .WIDE_W(WIDE_W)
    ) clamp_i (
        .val     (wide_d),
        .uns_mode(uns_d),
        .clamped (sat_y)
    );

    always_comb begin
        case (hsimd_op_e'(op))
            OP_AVG:  y = avg_d;
            OP_NONE: y = '0;
            default: y = sat_y;
        endcase
    end

endmodule

// File: rtl/hsimd_alu.sv
module hsimd_alu
    import hsimd_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANES  = LANES_DEF,
    parameter int SH_W   = SH_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [OP_W-1:0]           op,
    input  logic [LANES*LANE_W-1:0]   src_a,
    input  logic [LANES*LANE_W-1:0]   src_b,
    input  logic [SH_W-1:0]           shamt,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   result
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } alu_state_t;

    alu_state_t        state_d;
    alu_state_t        state_q;
    logic [DATA_W-1:0] lanes_y;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        hsimd_lane #(
            .LANE_W(LANE_W),
            .SH_W  (SH_W)
        ) lane_i (
            .op   (op),
            .shamt(shamt),
            .a    (src_a[k*LANE_W +: LANE_W]),
            .b    (src_b[k*LANE_W +: LANE_W]),
            .y    (lanes_y[k*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = lanes_y;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;

endmodule

// File: rtl/hsimd_alu_chk.sv
module hsimd_alu_chk #(
    parameter int LANE_W = 16,
    parameter int LANES  = 4,
    parameter int SH_W   = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [2:0]              op,
    input logic [LANES*LANE_W-1:0] src_a,
    input logic [LANES*LANE_W-1:0] src_b,
    input logic [SH_W-1:0]         shamt,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] result
);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R7
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd7) |=> (result == '0));

    // R4
    avg_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd4 && src_a == src_b) |=> (result == $past(src_a)));

endmodule

bind hsimd_alu hsimd_alu_chk #(
    .LANE_W(LANE_W),
    .LANES (LANES),
    .SH_W  (SH_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op       (op),
    .src_a    (src_a),
    .src_b    (src_b),
    .shamt    (shamt),
    .out_valid(out_valid),
    .result   (result)
);

// File: tb/hsimd_alu_tb.sv
`timescale 1ns/1ps
module hsimd_alu_tb_top;

    localparam int NV = 11;

    localparam logic [2:0] V_OP [NV] = '{
        3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd6, 3'd6, 3'd7, 3'd6
    };
    localparam logic [1:0] V_SH [NV] = '{
        2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd1, 2'd2, 2'd0, 2'd0, 2'd3
    };
    localparam logic [63:0] V_A [NV] = '{
        64'h7FFF_8000_0001_FFFF, 64'hFFFF_0005_8000_0010,
        64'h8000_7FFF_0005_0000, 64'h0000_FFFF_1234_0010,
        64'hFFFF_0001_0004_0003, 64'h1000_F000_0001_FFFF,
        64'h4000_0003_C000_0000, 64'hFFFF_8000_0010_7FFF,
        64'h7FFF_8000_0003_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'hFFF9_0000_0000_0000
    };
    localparam logic [63:0] V_B [NV] = '{
        64'h0001_FFFF_0002_FFFF, 64'h0001_FFF0_8000_FFFF,
        64'h0001_FFFF_0007_8000, 64'h0001_FFFF_0234_0020,
        64'hFFFF_0002_0006_0000, 64'h0000_0000_0005_0001,
        64'h0000_0001_FFFF_1234, 64'h0000_0001_0001_7FFF,
        64'h0001_8000_0004_0000, 64'h1234_5678_9ABC_DEF0,
        64'h0000_0000_0000_0000
    };
    localparam logic [63:0] V_EXP [NV] = '{
        64'h7FFF_8000_0003_FFFE, 64'hFFFF_0000_0000_000F,
        64'h8000_7FFF_FFFE_7FFF, 64'h0000_FFFF_1000_0000,
        64'hFFFF_0001_0005_0001, 64'h7FFF_8000_000D_FFF9,
        64'h7FFF_0007_8000_1234, 64'hFFFF_E001_0005_7FFF,
        64'h7FFF_8000_0007_0000, 64'h0000_0000_0000_0000,
        64'hFFFF_0000_0000_0000
    };
    localparam string V_REQ [NV] = '{
        "R2 R1", "R3 R1", "R2", "R3", "R4 R1", "R5", "R5", "R6 R1", "R6", "R7", "R6"
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [1:0]  shamt = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [63:0] held;

    always #4 clk = ~clk;

    hsimd_alu dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .op       (op),
        .src_a    (src_a),
        .src_b    (src_b),
        .shamt    (shamt),
        .out_valid(out_valid),
        .result   (result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid", {63'd0, out_valid}, 64'd0);
        check("R10 result", result, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            op       = V_OP[i];
            shamt    = V_SH[i];
            src_a    = V_A[i];
            src_b    = V_B[i];
            @(negedge clk);
            check(V_REQ[i], result, V_EXP[i]);
            check("R8 valid", {63'd0, out_valid}, 64'd1);
        end

        // R9: idle request with new inputs leaves the result alone
        held     = result;
        in_valid = 1'b0;
        op       = 3'd0;
        src_a    = 64'h0001_0001_0001_0001;
        src_b    = 64'h0001_0001_0001_0001;
        @(negedge clk);
        check("R9 hold", result, held);
        check("R8 drop", {63'd0, out_valid}, 64'd0);
        op = 3'd7;
        @(negedge clk);
        check("R9 hold undef", result, held);

        // R4: odd sum rounds up via OR
        in_valid = 1'b1;
        op       = 3'd4;
        src_a    = 64'h0001_0000_7FFF_8001;
        src_b    = 64'h0004_0001_8000_8000;
        @(negedge clk);
        check("R4 odd", result, 64'h0003_0001_7FFF_8001);

        // R10: reset mid-run clears result and valid
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        check("R10 mid", result, 64'd0);
        check("R10 mid valid", {63'd0, out_valid}, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule